// File: doc/BRIEF.md
# Single-to-Double Float Widening Unit

This block takes one 32-bit binary32 word per accepted strobe and returns the same value as a 64-bit binary64 word together with a 3-bit class tag, one clock later. Finite inputs are converted as numbers. The exponent is rebiased and the fraction is padded. Binary32 subnormals are renormalised so that the result is an ordinary normal double.

Inputs with an all-ones exponent are not converted arithmetically. Infinities keep their sign. NaNs keep their sign and their full 23-bit payload. The one "indefinite" NaN pattern, 0xFFC00000, gets a fixed replacement word. A build parameter chooses the quiet-bit convention of the output NaNs. In native mode, a set top fraction bit means quiet. In inverted mode, that bit is flipped, and the indefinite pattern becomes the inverted-convention default NaN.

For NaNs, the tag is taken from the input. For every other value it is read from the widened double, not from the source encoding. A core that keeps per-register class tags next to its data can therefore store both halves of the result directly.

Top module: `fwid_top`

## Requirements
- R1: While rst_n is low at a rising edge, the registered outputs become out_valid=0, out_data=0 and out_tag=1 (ZERO). Tag codes are VALID=0, ZERO=1, DENORM=2, INFINITY=3, QNAN=4, SNAN=5, INDEF=6.
- R2: out_valid equals the in_valid value of the previous cycle. out_data and out_tag load only when in_valid was high, and otherwise keep their previous values.
- R3: A normal input (exponent field in_data[30:23] between 1 and 254) produces the same sign, the exponent field plus 896, and the 23-bit fraction followed by 29 zero bits. Its tag is VALID.
- R4: A zero input of either sign produces a double zero of the same sign (bit 63), with tag ZERO.
- R5: A subnormal input (exponent field 0, fraction f nonzero) is renormalised. With z leading zeros in f, the double exponent is 896 − z and the fraction is f shifted left by z+1 (hidden one dropped), then padded. Its tag is VALID.
- R6: 0x7F800000 yields 0x7FF0000000000000 and 0xFF800000 yields 0xFFF0000000000000. Both are tagged INFINITY.
- R7: 0xFFC00000 is tagged INDEF. It yields 0xFFF8000000000000 when INVERT_QUIET=0 and 0x7FF7FFFFFFFFFFFF when INVERT_QUIET=1.
- R8: Any other NaN is tagged QNAN when input bit 22 is 1 and SNAN when it is 0. This holds in both modes.
- R9: Any other NaN yields the sign bit, exponent 0x7FF, the 23 input fraction bits in output bits 51:29 and zeros in bits 28:0. When INVERT_QUIET=1, input bit 22 is inverted (output bit 51).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: in_data is to be converted |
| in_data | input | 32 | binary32 source word |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 64 | binary64 result |
| out_tag | output | 3 | Class tag of the result |

## Verification
The bench builds two copies side by side from the same stimulus: u0 with INVERT_QUIET=0 and u1 with INVERT_QUIET=1. Only in this way can both replacement words for the indefinite pattern and both payload polarities be checked in one run. Random words are biased toward NaN payloads and subnormal fractions with every leading-zero count. This covers the full range of the renormalising shift and the signalling/quiet split.

// File: rtl/fwid_pkg.sv
package fwid_pkg;

    parameter int SP_W      = 32;
    parameter int SP_EXP_W  = 8;
    parameter int SP_FRAC_W = 23;
    parameter int DP_W      = 64;
    parameter int DP_EXP_W  = 11;
    parameter int DP_FRAC_W = 52;
    parameter int SP_BIAS   = 127;
    parameter int DP_BIAS   = 1023;

    localparam int BIAS_DELTA = DP_BIAS - SP_BIAS;
    localparam int FRAC_PAD   = DP_FRAC_W - SP_FRAC_W;
    localparam int LZC_W      = $clog2(SP_FRAC_W + 1);
    localparam int TAG_W      = 3;

    localparam logic [SP_W-1:0] SP_INDEF     = 32'hFFC0_0000;
    localparam logic [DP_W-1:0] DP_INDEF_NAT = 64'hFFF8_0000_0000_0000;
    localparam logic [DP_W-1:0] DP_INDEF_INV = 64'h7FF7_FFFF_FFFF_FFFF;

    typedef enum logic [TAG_W-1:0] {
        CLS_VALID  = 3'd0,
        CLS_ZERO   = 3'd1,
        CLS_DENORM = 3'd2,
        CLS_INF    = 3'd3,
        CLS_QNAN   = 3'd4,
        CLS_SNAN   = 3'd5,
        CLS_INDEF  = 3'd6
    } fwid_cls_e;

    typedef struct packed {
        logic              valid;
        logic [DP_W-1:0]   data;
        fwid_cls_e         cls;
    } fwid_out_s;

endpackage

// File: rtl/fwid_lzc.sv
module fwid_lzc #(
    parameter int W  = 23,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Scan upward; the highest set bit is the last one to write cnt.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fwid_numeric.sv
module fwid_numeric
    import fwid_pkg::*;
(
    input  logic                 sign,
    input  logic [SP_EXP_W-1:0]  exp_in,
    input  logic [SP_FRAC_W-1:0] frac_in,
    output logic [DP_W-1:0]      word
);
    logic [LZC_W-1:0]     lead_zeros;
    logic [DP_EXP_W-1:0]  exp_d;
    logic [SP_FRAC_W-1:0] frac_d;

    fwid_lzc #(.W(SP_FRAC_W), .CW(LZC_W)) u_lzc (
        .vec (frac_in),
        .cnt (lead_zeros)
    );

    always_comb begin
        if (exp_in != '0) begin
            exp_d  = DP_EXP_W'(exp_in) + DP_EXP_W'(BIAS_DELTA);
            frac_d = frac_in;
        end else if (frac_in == '0) begin
            exp_d  = '0;
            frac_d = '0;
        end else begin
            // Move the leading one into the hidden position, then drop it.
            exp_d  = DP_EXP_W'(BIAS_DELTA) - DP_EXP_W'(lead_zeros);
            frac_d = frac_in << (LZC_W'(1) + lead_zeros);
        end
        word = {sign, exp_d, frac_d, {FRAC_PAD{1'b0}}};
    end
endmodule

// File: rtl/fwid_special.sv
module fwid_special
    import fwid_pkg::*;
#(
    parameter bit INVERT_QUIET = 1'b0
) (
    input  logic [SP_W-1:0] src,
    output logic [DP_W-1:0] word,
    output fwid_cls_e       cls
);
    localparam int QBIT = SP_FRAC_W - 1;

    logic                 sign;
    logic [SP_FRAC_W-1:0] payload;
    logic [SP_FRAC_W-1:0] payload_out;

    assign sign    = src[SP_W-1];
    assign payload = src[SP_FRAC_W-1:0];

    generate
        if (INVERT_QUIET) begin : g_flip
            assign payload_out = payload ^ (SP_FRAC_W'(1) << QBIT);
        end else begin : g_keep
            assign payload_out = payload;
        end
    endgenerate

    always_comb begin
        if (payload == '0) begin
            word = {sign, {DP_EXP_W{1'b1}}, {DP_FRAC_W{1'b0}}};
            cls  = CLS_INF;
        end else if (src == SP_INDEF) begin
            word = INVERT_QUIET ? DP_INDEF_INV : DP_INDEF_NAT;
            cls  = CLS_INDEF;
        end else begin
            word = {sign, {DP_EXP_W{1'b1}}, payload_out, {FRAC_PAD{1'b0}}};
            cls  = payload[QBIT] ? CLS_QNAN : CLS_SNAN;
        end
    end
endmodule

// File: rtl/fwid_dp_class.sv
module fwid_dp_class
    import fwid_pkg::*;
(
    input  logic [DP_W-1:0] word,
    output fwid_cls_e       cls
);
    logic [DP_EXP_W-1:0] dexp;
    assign dexp = word[DP_W-2 -: DP_EXP_W];

    always_comb begin
        if (word[DP_W-2:0] == '0)   cls = CLS_ZERO;
        else if (dexp == '0)        cls = CLS_DENORM;
        else                        cls = CLS_VALID;
    end
endmodule

// File: rtl/fwid_top.sv
module fwid_top
    import fwid_pkg::*;
#(
    parameter bit INVERT_QUIET = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        out_valid,
    output logic [63:0] out_data,
    output logic [2:0]  out_tag
);
    localparam fwid_out_s RESET_VAL = '{valid: 1'b0, data: '0, cls: CLS_ZERO};

    logic [DP_W-1:0] num_word;
    logic [DP_W-1:0] spec_word;
    fwid_cls_e       num_cls;
    fwid_cls_e       spec_cls;
    logic            is_special;
    fwid_out_s       res_d, res_q;

    assign is_special = &in_data[SP_W-2 -: SP_EXP_W];

    fwid_numeric u_num (
        .sign    (in_data[SP_W-1]),
        .exp_in  (in_data[SP_W-2 -: SP_EXP_W]),
        .frac_in (in_data[SP_FRAC_W-1:0]),
        .word    (num_word)
    );

    fwid_dp_class u_cls (
        .word (num_word),
        .cls  (num_cls)
    );

    fwid_special #(.INVERT_QUIET(INVERT_QUIET)) u_spec (
        .src  (in_data),
        .word (spec_word),
        .cls  (spec_cls)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.data = is_special ? spec_word : num_word;
            res_d.cls  = is_special ? spec_cls  : num_cls;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= RESET_VAL;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_data  = res_q.data;
    assign out_tag   = res_q.cls;
endmodule

// File: rtl/fwid_chk.sv
module fwid_chk #(
    parameter bit INVERT_QUIET = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic [63:0] out_data,
    input logic [2:0]  out_tag
);
    logic in_special;
    logic sign_kept;
    assign in_special = &in_data[30:23];
    assign sign_kept  = !(INVERT_QUIET && in_data == 32'hFFC0_0000);

    assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_tag)));
    assert_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sign_kept) |=> out_data[63] == $past(in_data[31]));
    assert_finite_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_special) |=> (out_tag == 3'd0 || out_tag == 3'd1));
    assert_special_exp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_special) |=> (out_data[62:52] == 11'h7FF && out_tag >= 3'd3));
    assert_zero_mag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tag == 3'd1) |-> (out_data[62:0] == '0));
endmodule

bind fwid_top fwid_chk #(.INVERT_QUIET(INVERT_QUIET)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_tag   (out_tag)
);

// File: tb/sim_fwid_top.sv
`timescale 1ns/1ps
module sim_fwid_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        v0, v1;
    logic [63:0] d0, d1;
    logic [2:0]  t0, t1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fwid_top #(.INVERT_QUIET(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v0), .out_data(d0), .out_tag(t0));
    fwid_top #(.INVERT_QUIET(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v1), .out_data(d1), .out_tag(t1));

    function automatic logic [63:0] ref_word(logic [31:0] x, bit inv);
        logic       s = x[31];
        logic [7:0] e = x[30:23];
        logic [22:0] f = x[22:0];
        logic [22:0] m;
        int sh;
        if (e == 8'hFF) begin
            if (f == 0) return {s, 11'h7FF, 52'd0};
            if (x == 32'hFFC00000) return inv ? 64'h7FF7FFFFFFFFFFFF : 64'hFFF8000000000000;
            if (inv) f[22] = ~f[22];
            return {s, 11'h7FF, f, 29'd0};
        end
        if (e == 0) begin
            if (f == 0) return {s, 63'd0};
            m = f; sh = 0;
            while (!m[22]) begin m = m << 1; sh++; end
            return {s, 11'(896 - sh), m[21:0], 30'd0};
        end
        return {s, 11'(e) + 11'd896, f, 29'd0};
    endfunction

    function automatic logic [2:0] ref_tag(logic [31:0] x);
        if (x[30:23] == 8'hFF) begin
            if (x[22:0] == 0) return 3'd3;
            if (x == 32'hFFC00000) return 3'd6;
            return x[22] ? 3'd4 : 3'd5;
        end
        if (x[30:0] == 0) return 3'd1;
        return 3'd0;
    endfunction

    function automatic string req_of(logic [31:0] x);
        if (x[30:23] == 8'hFF) begin
            if (x[22:0] == 0) return "R6";
            if (x == 32'hFFC00000) return "R7";
            return "R8/R9";
        end
        if (x[30:0] == 0) return "R4";
        if (x[30:23] == 0) return "R5";
        return "R3";
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one word, wait for the registered result, compare both copies.
    task automatic apply(logic [31:0] x);
        string r;
        r = req_of(x);
        in_valid = 1'b1; in_data = x;
        @(negedge clk);
        chk("R2 valid u0", 64'(v0), 64'd1);
        chk({r, " data u0"}, d0, ref_word(x, 1'b0));
        chk({r, " tag u0"}, 64'(t0), 64'(ref_tag(x)));
        chk({r, " data u1"}, d1, ref_word(x, 1'b1));
        chk({r, " tag u1"}, 64'(t1), 64'(ref_tag(x)));
    endtask

    // Idle cycle with a different word on the bus: outputs must hold.
    task automatic idle(logic [31:0] junk);
        logic [63:0] h0, h1;
        logic [2:0]  g0, g1;
        h0 = d0; h1 = d1; g0 = t0; g1 = t1;
        in_valid = 1'b0; in_data = junk;
        @(negedge clk);
        chk("R2 idle valid", 64'(v0 | v1), 64'd0);
        chk("R2 hold data", d0 ^ d1, h0 ^ h1);
        chk("R2 hold u0", d0, h0);
        chk("R2 hold tag", {58'd0, t0, t1}, {58'd0, g0, g1});
    endtask

    initial begin
        logic [31:0] w;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", 64'(v0 | v1), 64'd0);
        chk("R1 data", d0 | d1, 64'd0);
        chk("R1 tag", {58'd0, t0, t1}, {58'd0, 3'd1, 3'd1});
        rst_n = 1'b1;
        @(negedge clk);

        apply(32'h3F800000);               // R3 1.0
        chk("R3 one", d0, 64'h3FF0000000000000);
        apply(32'h7F7FFFFF);               // R3 max normal
        apply(32'h00800000);               // R3 min normal
        apply(32'h00000000);               // R4 +0
        apply(32'h80000000);               // R4 -0
        chk("R4 neg zero sign", d0, 64'h8000000000000000);
        apply(32'h00000001);               // R5 min subnormal
        chk("R5 min sub", d0, 64'h36A0000000000000);
        apply(32'h807FFFFF);               // R5 max subnormal
        apply(32'h00400000);               // R5
        apply(32'h7F800000);               // R6
        apply(32'hFF800000);               // R6
        apply(32'hFFC00000);               // R7
        chk("R7 inv", d1, 64'h7FF7FFFFFFFFFFFF);
        apply(32'h7FC00000);               // R8 quiet, positive
        apply(32'h7F800001);               // R8 signalling
        apply(32'hFFBFFFFF);               // R9 full payload
        apply(32'h7FFFFFFF);
        apply(32'hFFC00001);               // near-indef
        idle(32'h7F800000);

        for (int i = 0; i < 600; i++) begin
            case ($urandom % 4)
                0: w = $urandom;
                1: w = {1'($urandom), 8'hFF, 23'($urandom)};
                2: w = {1'($urandom), 8'h00, 23'($urandom) >> ($urandom % 23)};
                default: w = {1'($urandom), 8'(1 + $urandom % 254), 23'($urandom)};
            endcase
            apply(w);
            if ($urandom % 5 == 0) idle($urandom);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule